// File: doc/BRIEF.md
# Interleaved Micro-Packet Stream Reassembler

This block receives 32-bit words that carry three-byte slices of 188-byte transport packets belonging to up to four streams, interleaved in any order. Each word names its stream, may mark the start of a packet, and carries a 3-bit rolling counter and an upstream-overflow indication. The block routes each word to the reassembly state of its stream, tracks where in the packet that stream stands, and emits the payload bytes one per cycle. Each byte is tagged with its stream index and with start-of-packet and end-of-packet markers.

Words are taken on a valid/ready handshake. The output is a plain byte stream with no back-pressure: one byte per cycle while a word is being unpacked. Per-stream sticky loss flags record continuity breaks. A sticky overflow flag records any overflow indication seen upstream. Both kinds of flag stay set until a clear strobe or a reset.

Top module: `mpkt_reasm`

## Requirements
- R1: Bits 31:29 of a word give stream number plus one. Values 1 to 4 select streams 0 to 3. A word with any other value is consumed but produces no output bytes, and it changes no flag even when bit 24 is set.
- R2: A word with bit 25 set starts a new packet on its stream. Its first byte is byte 0 of a packet, whatever the stream's position was before.
- R3: A word with bit 25 clear that reaches a stream at position zero is dropped. Position zero holds after reset and after a completed packet. A dropped word emits no bytes.
- R4: An accepted word emits bits 23:16 first, then 15:8, then 7:0. The bytes come out on consecutive cycles, starting the cycle after the handshake, each tagged on out_stream with the word's stream.
- R5: A packet takes 63 words. The 63rd word emits only its bits 23:16 and 15:8, so a packet is 188 bytes. out_sop marks byte 0 and out_eop marks byte 187. After the 63rd word the stream returns to position zero.
- R6: Bits 28:26 are a per-stream counter. An accepted word whose counter is not the stream's stored counter plus one, modulo 8, sets bit s of loss_flags for stream s. The stored counter takes the word's value whether or not it matched.
- R7: The first accepted word of a stream after reset is not checked for continuity.
- R8: An accepted word with bit 24 set raises ovf_flag.
- R9: loss_flags and ovf_flag are sticky. They clear only on clr_flags or on reset. An event in the same cycle as clr_flags still sets its flag.
- R10: Each stream keeps its own position and counter, so words of other streams interleaved between its words do not alter its packets.
- R11: in_ready is low while bytes of a word remain to be emitted. It returns high in the cycle that emits the word's last byte.
- R12: After reset out_valid, out_sop, out_eop, loss_flags and ovf_flag are 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_word | input | 32 | Input micro-packet word |
| in_ready | output | 1 | Block can take a word this cycle |
| clr_flags | input | 1 | Clears loss and overflow flags |
| out_valid | output | 1 | Output byte valid |
| out_byte | output | 8 | Payload byte |
| out_stream | output | 2 | Stream of the output byte |
| out_sop | output | 1 | Byte 0 of a packet |
| out_eop | output | 1 | Byte 187 of a packet |
| loss_flags | output | 4 | Sticky continuity loss, one bit per stream |
| ovf_flag | output | 1 | Sticky upstream overflow |

## Verification
The embedded assertions check the following on every cycle:
- flags never fall without a clear;
- the stream tag holds and output continues while in_ready is low;
- start and end markers never coincide;
- an out-of-range stream word never yields a byte.

Only the directed scenarios can show the rest:
- the byte values and their order;
- the 188-byte length and marker placement;
- dropping before a start marker and restarting mid-packet;
- the exemption for a stream's first word, and counter resynchronisation after a mismatch;
- stream independence under interleaving.

// File: rtl/mpkt_reasm.sv
module mpkt_reasm #(
  parameter int NS  = 4,
  parameter int UPK = 63
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_word,
  output logic          in_ready,
  input  logic          clr_flags,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic [$clog2(NS)-1:0] out_stream,
  output logic          out_sop,
  output logic          out_eop,
  output logic [NS-1:0] loss_flags,
  output logic          ovf_flag
);
  localparam int SW   = $clog2(NS);
  localparam int POSW = $clog2(UPK);

  logic [POSW-1:0] pos   [NS];
  logic [2:0]      lastc [NS];
  logic [NS-1:0]   seen;

  logic            busy;
  logic [1:0]      bidx, nb;
  logic [23:0]     hold;
  logic [SW-1:0]   ostr;
  logic [POSW-1:0] opos;

  wire [2:0]      sid1   = in_word[31:29];
  wire            sid_ok = (sid1 >= 3'd1) && (sid1 <= 3'(NS));
  wire [SW-1:0]   sid    = SW'(sid1 - 3'd1);
  wire            st     = in_word[25];
  wire [2:0]      wcnt   = in_word[28:26];
  wire            take   = in_valid && in_ready && sid_ok;
  wire [POSW-1:0] cur    = st ? '0 : pos[sid];
  wire            keep   = take && (st || pos[sid] != '0);
  wire            lupk   = (cur == POSW'(UPK - 1));
  wire            mism   = seen[sid] && (wcnt != lastc[sid] + 3'd1);
  wire            lastb  = busy && (bidx == nb - 2'd1);
  wire [NS-1:0]   sel    = NS'(1) << sid;

  assign in_ready   = !busy || lastb;
  assign out_valid  = busy;
  assign out_stream = ostr;
  assign out_byte   = (bidx == 2'd0) ? hold[23:16] :
                      (bidx == 2'd1) ? hold[15:8]  : hold[7:0];
  assign out_sop    = busy && opos == '0 && bidx == 2'd0;
  assign out_eop    = lastb && opos == POSW'(UPK - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      bidx       <= '0;
      nb         <= 2'd3;
      hold       <= '0;
      ostr       <= '0;
      opos       <= '0;
      seen       <= '0;
      loss_flags <= '0;
      ovf_flag   <= 1'b0;
      for (int i = 0; i < NS; i++) begin
        pos[i]   <= '0;
        lastc[i] <= '0;
      end
    end else begin
      if (keep) begin
        hold       <= in_word[23:0];
        ostr       <= sid;
        opos       <= cur;
        nb         <= lupk ? 2'd2 : 2'd3;
        busy       <= 1'b1;
        bidx       <= '0;
        pos[sid]   <= lupk ? '0 : cur + POSW'(1);
        lastc[sid] <= wcnt;
        seen[sid]  <= 1'b1;
      end else if (busy) begin
        if (lastb) busy <= 1'b0;
        else       bidx <= bidx + 2'd1;
      end
      loss_flags <= (clr_flags ? '0 : loss_flags) | ((keep && mism) ? sel : '0);
      ovf_flag   <= (clr_flags ? 1'b0 : ovf_flag) | (keep && in_word[24]);
    end
  end

  // R9
  loss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> (($past(loss_flags) & ~loss_flags) == '0));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags && ovf_flag |=> ovf_flag);
  // R11
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_ready |=> out_valid);
  // R4
  stream_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !in_ready |=> $stable(out_stream));
  // R5
  sop_eop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sop |-> !out_eop);
  // R1
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_word[31:29] == 3'd0 || in_word[31:29] > 3'(NS)) |=> !out_valid);
endmodule

// File: tb/sim_mpkt_reasm.sv
module sim_mpkt_reasm;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, clr_flags = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, out_valid, out_sop, out_eop, ovf_flag;
  logic [7:0] out_byte;
  logic [1:0] out_stream;
  logic [3:0] loss_flags;

  mpkt_reasm u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .in_ready(in_ready), .clr_flags(clr_flags), .out_valid(out_valid),
    .out_byte(out_byte), .out_stream(out_stream), .out_sop(out_sop),
    .out_eop(out_eop), .loss_flags(loss_flags), .ovf_flag(ovf_flag));

  always #5 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] cap [4][0:399];
  int ncap[4], nsop[4], neop[4], sop_at[4], eop_at[4];
  logic [2:0] tbcnt[4];

  always @(negedge clk) if (out_valid) begin
    if (ncap[out_stream] < 400) cap[out_stream][ncap[out_stream]] = out_byte;
    if (out_sop) begin nsop[out_stream]++; sop_at[out_stream] = ncap[out_stream]; end
    if (out_eop) begin neop[out_stream]++; eop_at[out_stream] = ncap[out_stream]; end
    ncap[out_stream]++;
  end

  task automatic chk(string r, string what, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic clear_cap();
    for (int s = 0; s < 4; s++) begin
      ncap[s] = 0; nsop[s] = 0; neop[s] = 0; sop_at[s] = -1; eop_at[s] = -1;
    end
  endtask

  task automatic send(input logic [2:0] sid1, input logic [2:0] c, input logic st,
                      input logic ov, input logic [23:0] pay);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = {sid1, c, st, ov, pay};
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_upk(int s, int j, int base);
    logic [7:0] b = 8'(base + 3 * j);
    send(3'(s + 1), tbcnt[s], j == 0, 1'b0, {b, b + 8'd1, b + 8'd2});
    tbcnt[s] = tbcnt[s] + 3'd1;
  endtask

  task automatic flush();
    repeat (5) @(negedge clk);
  endtask

  function automatic int bad_bytes(int s, int off, int base);
    int e = 0;
    for (int k = 0; k < 188; k++) if (cap[s][off + k] != 8'(base + k)) e++;
    return e;
  endfunction

  task automatic pulse_clr();
    @(negedge clk); clr_flags = 1'b1;
    @(negedge clk); clr_flags = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12", "out_valid", out_valid, 0);
    chk("R12", "in_ready", in_ready, 1);
    chk("R12", "loss_flags", loss_flags, 0);
    chk("R12", "ovf_flag", ovf_flag, 0);
  endtask

  task automatic t_full();
    clear_cap();
    tbcnt[0] = 3'd5;
    for (int j = 0; j < 63; j++) send_upk(0, j, 0);
    flush();
    chk("R5", "byte count", ncap[0], 188);
    chk("R4", "bad bytes", bad_bytes(0, 0, 0), 0);
    chk("R5", "sop index", sop_at[0], 0);
    chk("R5", "eop index", eop_at[0], 187);
    chk("R5", "sop/eop count", nsop[0] * 10 + neop[0], 11);
    chk("R7", "loss after first word", loss_flags, 0);
  endtask

  task automatic t_ready();
    clear_cap();
    tbcnt[1] = 3'd0;
    send(3'd2, tbcnt[1], 1'b1, 1'b0, 24'hA1B2C3);
    tbcnt[1] = tbcnt[1] + 3'd1;
    chk("R11", "ready after accept", in_ready, 0);
    chk("R11", "valid after accept", out_valid, 1);
    chk("R4", "first byte", out_byte, 8'hA1);
    chk("R4", "stream tag", out_stream, 1);
    @(negedge clk);
    chk("R11", "ready mid word", in_ready, 0);
    chk("R4", "second byte", out_byte, 8'hB2);
    @(negedge clk);
    chk("R11", "ready on last byte", in_ready, 1);
    chk("R4", "third byte", out_byte, 8'hC3);
    flush();
  endtask

  task automatic t_drop();
    clear_cap();
    send(3'd4, 3'd0, 1'b0, 1'b0, 24'h111111);
    flush();
    chk("R3", "bytes from unstarted stream", ncap[3], 0);
    send(3'd0, 3'd0, 1'b1, 1'b1, 24'h222222);
    send(3'd6, 3'd0, 1'b1, 1'b1, 24'h333333);
    flush();
    chk("R1", "bytes from bad ids", ncap[0] + ncap[1] + ncap[2] + ncap[3], 0);
    chk("R1", "ovf from bad ids", ovf_flag, 0);
  endtask

  task automatic t_interleave();
    clear_cap();
    tbcnt[2] = 3'd3; tbcnt[3] = 3'd6;
    for (int j = 0; j < 63; j++) begin
      send_upk(2, j, 0);
      send_upk(3, j, 100);
    end
    flush();
    chk("R10", "stream2 count", ncap[2], 188);
    chk("R10", "stream3 count", ncap[3], 188);
    chk("R10", "stream2 bytes", bad_bytes(2, 0, 0), 0);
    chk("R10", "stream3 bytes", bad_bytes(3, 0, 100), 0);
    chk("R7", "no loss on first words", loss_flags, 0);
  endtask

  task automatic t_restart();
    clear_cap();
    for (int j = 1; j < 5; j++) send_upk(1, j, 40);
    for (int j = 0; j < 63; j++) send_upk(1, j, 7);
    flush();
    chk("R2", "total bytes", ncap[1], 200);
    chk("R2", "sop count", nsop[1], 1);
    chk("R2", "sop index", sop_at[1], 12);
    chk("R2", "eop index", eop_at[1], 199);
    chk("R2", "restarted bytes", bad_bytes(1, 12, 7), 0);
  endtask

  task automatic t_loss();
    tbcnt[0] = tbcnt[0] + 3'd1;
    send_upk(0, 0, 0);
    chk("R6", "loss on mismatch", loss_flags, 4'b0001);
    send_upk(0, 1, 0);
    chk("R9", "loss sticky", loss_flags, 4'b0001);
    pulse_clr();
    chk("R9", "loss cleared", loss_flags, 0);
    send_upk(0, 2, 0);
    chk("R6", "stored counter updated", loss_flags, 0);
    flush();
  endtask

  task automatic t_ovf();
    send(3'd3, tbcnt[2], 1'b1, 1'b1, 24'h0);
    tbcnt[2] = tbcnt[2] + 3'd1;
    chk("R8", "ovf set", ovf_flag, 1);
    send_upk(2, 1, 0);
    chk("R9", "ovf sticky", ovf_flag, 1);
    pulse_clr();
    chk("R9", "ovf cleared", ovf_flag, 0);
    send(3'd3, tbcnt[2], 1'b0, 1'b1, 24'h0);
    tbcnt[2] = tbcnt[2] + 3'd1;
    flush();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9", "ovf cleared by reset", ovf_flag, 0);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    clear_cap();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_ready();
    t_drop();
    t_interleave();
    t_restart();
    t_loss();
    t_ovf();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule